// File: doc/BRIEF.md
# SPI Status Flag and Request Router

This block sits next to a queued SPI controller and turns the controller's activity into service requests. It watches event strobes from the shift engine (frame finished, end-of-queue command finished, transfer started by an external master, frame received) and the occupancy counts of the transmit and receive FIFOs. From these it keeps six status flags. Four of the flags record events and stay set until software clears them. Two of the flags follow FIFO levels.

Each flag has its own enable bit. An enabled flag drives its own interrupt line. A combined interrupt line is high whenever any of the per-flag interrupt lines is high. The two FIFO-level conditions (transmit room and receive data) can each be steered to a DMA request line instead of the interrupt line by a route bit. Software writes the enables and the route bits through simple write strobes, and clears event flags by writing ones.

All request outputs are registered. The flags are also registered, one cycle after the input that causes them.

Top module: `spi_req_router`

## Requirements
- R1: While rst_n is low at a clock edge, all flags, enables and route bits are cleared, and every request output is low after that edge.
- R2: A frame_done strobe sets the transfer-complete flag (flags bit 2) at the next edge. When eoq_cmd is also high, it additionally sets the end-of-queue flag (flags bit 0).
- R3: Event flags (bits 0, 2, 3, 5) stay set until a clr_we write with a 1 in that bit position clears them. A set event in the same cycle as the clearing write wins, and the flag stays set.
- R4: The transmit-room flag (bit 1) is high one cycle after tx_count is below DEPTH, and low one cycle after tx_count reaches DEPTH. Clearing writes do not change it.
- R5: The receive-data flag (bit 4) is high one cycle after rx_count is non-zero, and low one cycle after rx_count is zero.
- R6: The underflow flag (bit 3) is set by xfer_start_ext only when slave_mode and spi_fmt are both high and tx_count is zero. In every other case it is not set.
- R7: The overflow flag (bit 5) is set by rx_frame_in only when rx_count equals DEPTH.
- R8: irq[i] goes high one cycle after flag i and enable i (en_wdata bit i, written with en_we) are both set. It goes low one cycle after either one clears.
- R9: Route bit 0 (sel_wdata[0]) sends the transmit-room request to dma_tx_fill instead of irq[1]. Route bit 1 (sel_wdata[1]) sends the receive-data request to dma_rx_drain instead of irq[4]. The output that is not selected stays low.
- R10: irq_any equals the OR of the six irq lines in every cycle.
- R11: Only flags 1 and 4 can raise a DMA line. The other four conditions reach interrupt lines only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_done | input | 1 | Strobe: a serial frame has finished |
| eoq_cmd | input | 1 | The finishing command carries the end-of-queue mark |
| xfer_start_ext | input | 1 | Strobe: an external master has started a transfer |
| rx_frame_in | input | 1 | Strobe: a received frame is being pushed toward the RX FIFO |
| slave_mode | input | 1 | 1 = controller acts as a slave |
| spi_fmt | input | 1 | 1 = SPI framing selected |
| tx_count | input | CW | TX FIFO entry count |
| rx_count | input | CW | RX FIFO entry count |
| en_we | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 6 | New enable bits, one per flag |
| sel_we | input | 1 | Write strobe for the route bits |
| sel_wdata | input | 2 | Route bits: [0] transmit room to DMA, [1] receive data to DMA |
| clr_we | input | 1 | Write strobe for clearing flags |
| clr_wdata | input | 6 | Write-one-to-clear mask for the event flags |
| flags | output | 6 | Status flags: 0 end of queue, 1 TX room, 2 transfer complete, 3 TX underflow, 4 RX data, 5 RX overflow |
| irq | output | 6 | Per-condition interrupt requests, same bit order as flags |
| irq_any | output | 1 | Combined interrupt request |
| dma_tx_fill | output | 1 | DMA request for transmit room |
| dma_rx_drain | output | 1 | DMA request for receive data |

## Verification
A stimulus applied before a clock edge shows up in flags right after that edge. The irq, irq_any and DMA lines follow one edge later. A change to an enable or route bit takes one edge to be stored and one more edge to reach the request outputs. The bench drives inputs one time unit after a rising edge and reads outputs at the same offset. Each check therefore names exactly how many edges have passed since its stimulus. Checks also read the old value on the edge before the new one is due, so a result that arrives one cycle early is caught.

// File: rtl/spi_req_pkg.sv
// Shared constants for the SPI request router.
// Assumes six conditions with a fixed bit order. Software and the DMA hookup
// decode this order, so it must not change.
package spi_req_pkg;
    localparam int NCOND    = 6;
    localparam int C_EOQ    = 0;  // end of queue (event)
    localparam int C_TXFILL = 1;  // transmit room (level)
    localparam int C_TC     = 2;  // transfer complete (event)
    localparam int C_TXUF   = 3;  // transmit underflow (event)
    localparam int C_RXDRN  = 4;  // receive data (level)
    localparam int C_RXOV   = 5;  // receive overflow (event)

    // Flags that are sticky; the remaining flags follow a level.
    localparam logic [NCOND-1:0] EVENT_MASK = 6'b101101;

    // Flags that may be steered to a DMA line.
    localparam logic [NCOND-1:0] ROUTE_MASK = 6'b010010;
endpackage

// File: rtl/spi_req_cond.sv
// Condition detector: turns strobes and FIFO counts into one raw vector.
// Event bits are one-cycle set strobes. Level bits are the current FIFO
// condition. Assumes the counts never exceed DEPTH.
module spi_req_cond
    import spi_req_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             frame_done,
    input  logic             eoq_cmd,
    input  logic             xfer_start_ext,
    input  logic             rx_frame_in,
    input  logic             slave_mode,
    input  logic             spi_fmt,
    input  logic [CW-1:0]    tx_count,
    input  logic [CW-1:0]    rx_count,
    output logic [NCOND-1:0] cond_now
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // Build the raw condition vector from the current inputs.
    always_comb begin
        cond_now           = '0;
        cond_now[C_EOQ]    = frame_done & eoq_cmd;
        cond_now[C_TXFILL] = tx_count < FULL;
        cond_now[C_TC]     = frame_done;
        cond_now[C_TXUF]   = xfer_start_ext & slave_mode & spi_fmt & (tx_count == '0);
        cond_now[C_RXDRN]  = rx_count != '0;
        cond_now[C_RXOV]   = rx_frame_in & (rx_count >= FULL);
    end
endmodule

// File: rtl/spi_req_flags.sv
// Flag bank: one register per condition.
// Event flags are sticky and cleared by write-one-to-clear; a set wins over
// a clear in the same cycle. Level flags copy their condition every cycle
// and ignore clearing writes.
module spi_req_flags
    import spi_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCOND-1:0] cond_now,
    input  logic             clr_we,
    input  logic [NCOND-1:0] clr_wdata,
    output logic [NCOND-1:0] flag_q
);
    for (genvar i = 0; i < NCOND; i++) begin : g_flag
        if (EVENT_MASK[i]) begin : g_sticky
            // Sticky event flag with set priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q[i] <= 1'b0;
                else if (cond_now[i])
                    flag_q[i] <= 1'b1;
                else if (clr_we && clr_wdata[i])
                    flag_q[i] <= 1'b0;
            end
        end else begin : g_level
            // Level flag tracking the FIFO condition.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q[i] <= 1'b0;
                else
                    flag_q[i] <= cond_now[i];
            end
        end
    end
endmodule

// File: rtl/spi_req_route.sv
// Request router: gates each flag with its enable and steers the routable
// ones to either the interrupt or the DMA line. All outputs are registered.
// The combined interrupt line is built from the same next-state values, so
// it lines up with the per-condition lines.
module spi_req_route
    import spi_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCOND-1:0] flag_q,
    input  logic [NCOND-1:0] en_q,
    input  logic             tx_to_dma,
    input  logic             rx_to_dma,
    output logic [NCOND-1:0] irq,
    output logic             irq_any,
    output logic             dma_tx_fill,
    output logic             dma_rx_drain
);
    logic [NCOND-1:0] to_dma;
    logic [NCOND-1:0] active;
    logic [NCOND-1:0] irq_nxt;
    logic [NCOND-1:0] dma_nxt;

    // Spread the two route bits over the condition vector.
    always_comb begin
        to_dma           = '0;
        to_dma[C_TXFILL] = tx_to_dma;
        to_dma[C_RXDRN]  = rx_to_dma;
    end

    assign active = flag_q & en_q;

    for (genvar i = 0; i < NCOND; i++) begin : g_split
        if (ROUTE_MASK[i]) begin : g_routable
            assign irq_nxt[i] = active[i] & ~to_dma[i];
            assign dma_nxt[i] = active[i] &  to_dma[i];
        end else begin : g_irq_only
            assign irq_nxt[i] = active[i];
            assign dma_nxt[i] = 1'b0;
        end
    end

    // Register every request output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq          <= '0;
            irq_any      <= 1'b0;
            dma_tx_fill  <= 1'b0;
            dma_rx_drain <= 1'b0;
        end else begin
            irq          <= irq_nxt;
            irq_any      <= |irq_nxt;
            dma_tx_fill  <= dma_nxt[C_TXFILL];
            dma_rx_drain <= dma_nxt[C_RXDRN];
        end
    end
endmodule

// File: rtl/spi_req_router.sv
// Top of the SPI status flag and request router.
// Holds the enable and route registers and connects the condition detector,
// the flag bank and the request router. Assumes the write strobes are
// single-cycle and the FIFO counts are synchronous to clk.
module spi_req_router
    import spi_req_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic             eoq_cmd,
    input  logic             xfer_start_ext,
    input  logic             rx_frame_in,
    input  logic             slave_mode,
    input  logic             spi_fmt,
    input  logic [CW-1:0]    tx_count,
    input  logic [CW-1:0]    rx_count,
    input  logic             en_we,
    input  logic [NCOND-1:0] en_wdata,
    input  logic             sel_we,
    input  logic [1:0]       sel_wdata,
    input  logic             clr_we,
    input  logic [NCOND-1:0] clr_wdata,
    output logic [NCOND-1:0] flags,
    output logic [NCOND-1:0] irq,
    output logic             irq_any,
    output logic             dma_tx_fill,
    output logic             dma_rx_drain
);
    logic [NCOND-1:0] cond_now;
    logic [NCOND-1:0] en_q;
    logic [1:0]       sel_q;

    // Enable and route registers, loaded by their write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (sel_we) sel_q <= sel_wdata;
        end
    end

    spi_req_cond #(.DEPTH(DEPTH)) u_cond (
        .frame_done     (frame_done),
        .eoq_cmd        (eoq_cmd),
        .xfer_start_ext (xfer_start_ext),
        .rx_frame_in    (rx_frame_in),
        .slave_mode     (slave_mode),
        .spi_fmt        (spi_fmt),
        .tx_count       (tx_count),
        .rx_count       (rx_count),
        .cond_now       (cond_now)
    );

    spi_req_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_now  (cond_now),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .flag_q    (flags)
    );

    spi_req_route u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .flag_q       (flags),
        .en_q         (en_q),
        .tx_to_dma    (sel_q[0]),
        .rx_to_dma    (sel_q[1]),
        .irq          (irq),
        .irq_any      (irq_any),
        .dma_tx_fill  (dma_tx_fill),
        .dma_rx_drain (dma_rx_drain)
    );
endmodule

// File: rtl/spi_req_router_chk.sv
// Property checker for spi_req_router, attached with bind.
// Relates the flags, the stored enables and the request outputs over time.
module spi_req_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] flags,
    input logic [5:0] en_q,
    input logic [5:0] irq,
    input logic       irq_any,
    input logic       dma_tx_fill,
    input logic       dma_rx_drain,
    input logic       clr_we,
    input logic [5:0] clr_wdata,
    input logic       slave_mode
);
    // R10
    irq_any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (|irq));

    // R9
    tx_route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq[1], dma_tx_fill}));

    // R9
    rx_route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq[4], dma_rx_drain}));

    // R3
    tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags[2]) && !($past(clr_we) && $past(clr_wdata[2]))) |-> flags[2]);

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[2] |-> ($past(en_q[2]) && $past(flags[2])));

    // R6
    uf_slave_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> $past(slave_mode));

    // R11
    dma_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_tx_fill |-> $past(flags[1])) and (dma_rx_drain |-> $past(flags[4])));
endmodule

bind spi_req_router spi_req_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flags        (flags),
    .en_q         (en_q),
    .irq          (irq),
    .irq_any      (irq_any),
    .dma_tx_fill  (dma_tx_fill),
    .dma_rx_drain (dma_rx_drain),
    .clr_we       (clr_we),
    .clr_wdata    (clr_wdata),
    .slave_mode   (slave_mode)
);

// File: tb/test_spi_req_router.sv
module test_spi_req_router;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_done = 0, eoq_cmd = 0, xfer_start_ext = 0, rx_frame_in = 0;
    logic          slave_mode = 0, spi_fmt = 0;
    logic [CW-1:0] tx_count = CW'(DEPTH);
    logic [CW-1:0] rx_count = '0;
    logic          en_we = 0, sel_we = 0, clr_we = 0;
    logic [5:0]    en_wdata = '0, clr_wdata = '0;
    logic [1:0]    sel_wdata = '0;
    logic [5:0]    flags, irq;
    logic          irq_any, dma_tx_fill, dma_rx_drain;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    spi_req_router #(.DEPTH(DEPTH)) i_spi_req_router (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .eoq_cmd(eoq_cmd),
        .xfer_start_ext(xfer_start_ext), .rx_frame_in(rx_frame_in),
        .slave_mode(slave_mode), .spi_fmt(spi_fmt), .tx_count(tx_count),
        .rx_count(rx_count), .en_we(en_we), .en_wdata(en_wdata), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
        .flags(flags), .irq(irq), .irq_any(irq_any), .dma_tx_fill(dma_tx_fill),
        .dma_rx_drain(dma_rx_drain)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One clock edge, then settle one time unit past it.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic drop_strobes();
        frame_done = 0; eoq_cmd = 0; xfer_start_ext = 0; rx_frame_in = 0;
        en_we = 0; sel_we = 0; clr_we = 0;
    endtask

    task automatic clear_all();
        clr_we = 1; clr_wdata = 6'h3f; cyc(); drop_strobes(); cyc();
    endtask

    task automatic t_reset();
        rst_n = 0; cyc(); cyc(); cyc();
        chk("R1 flags", {2'b0, flags}, 8'h00);
        chk("R1 irq", {2'b0, irq}, 8'h00);
        chk("R1 other outs", {5'b0, irq_any, dma_tx_fill, dma_rx_drain}, 8'h00);
        rst_n = 1; cyc();
        chk("R1 flags after release", {2'b0, flags}, 8'h00);
    endtask

    task automatic t_events();
        frame_done = 1; eoq_cmd = 1; cyc(); drop_strobes();
        chk("R2 eoq and tc", {2'b0, flags}, 8'b00000101);
        clear_all();
        chk("R3 clear all", {2'b0, flags}, 8'h00);
        frame_done = 1; cyc(); drop_strobes();
        chk("R2 tc without eoq", {2'b0, flags}, 8'b00000100);
    endtask

    task automatic t_clear();
        cyc(); cyc();
        chk("R3 holds", {7'b0, flags[2]}, 8'd1);
        frame_done = 1; clr_we = 1; clr_wdata = 6'b000100; cyc(); drop_strobes();
        chk("R3 set wins", {7'b0, flags[2]}, 8'd1);
        clr_we = 1; clr_wdata = 6'b000001; cyc(); drop_strobes();
        chk("R3 other bit mask", {7'b0, flags[2]}, 8'd1);
        clr_we = 1; clr_wdata = 6'b000100; cyc(); drop_strobes();
        chk("R3 cleared", {7'b0, flags[2]}, 8'd0);
    endtask

    task automatic t_fill();
        tx_count = CW'(DEPTH - 1); #1;
        chk("R4 not yet", {7'b0, flags[1]}, 8'd0);
        cyc();
        chk("R4 room", {7'b0, flags[1]}, 8'd1);
        clr_we = 1; clr_wdata = 6'b000010; cyc(); drop_strobes();
        chk("R4 clear ignored", {7'b0, flags[1]}, 8'd1);
        tx_count = CW'(DEPTH); cyc();
        chk("R4 full", {7'b0, flags[1]}, 8'd0);
    endtask

    task automatic t_drain();
        rx_count = 1; cyc();
        chk("R5 data", {7'b0, flags[4]}, 8'd1);
        rx_count = 0; cyc();
        chk("R5 empty", {7'b0, flags[4]}, 8'd0);
    endtask

    task automatic t_underflow();
        tx_count = 0; xfer_start_ext = 1;
        slave_mode = 0; spi_fmt = 1; cyc();
        chk("R6 master", {7'b0, flags[3]}, 8'd0);
        slave_mode = 1; spi_fmt = 0; cyc();
        chk("R6 non-spi", {7'b0, flags[3]}, 8'd0);
        spi_fmt = 1; tx_count = 1; cyc();
        chk("R6 not empty", {7'b0, flags[3]}, 8'd0);
        tx_count = 0; cyc(); drop_strobes();
        chk("R6 set", {7'b0, flags[3]}, 8'd1);
        tx_count = CW'(DEPTH); slave_mode = 0;
        clear_all();
    endtask

    task automatic t_overflow();
        rx_count = CW'(DEPTH - 1); rx_frame_in = 1; cyc();
        chk("R7 not full", {7'b0, flags[5]}, 8'd0);
        rx_count = CW'(DEPTH); cyc(); drop_strobes();
        chk("R7 full", {7'b0, flags[5]}, 8'd1);
        rx_count = 0;
        clear_all();
    endtask

    task automatic t_irq();
        frame_done = 1; cyc(); drop_strobes(); cyc();
        chk("R8 disabled", {2'b0, irq}, 8'h00);
        en_we = 1; en_wdata = 6'h3f; cyc(); drop_strobes();
        chk("R8 one cycle late", {7'b0, irq[2]}, 8'd0);
        cyc();
        chk("R8 enabled", {2'b0, irq}, 8'b00000100);
        chk("R10 any high", {7'b0, irq_any}, 8'd1);
        clr_we = 1; clr_wdata = 6'b000100; cyc(); drop_strobes();
        chk("R8 still up", {7'b0, irq[2]}, 8'd1);
        cyc();
        chk("R8 dropped", {7'b0, irq[2]}, 8'd0);
        chk("R10 any low", {7'b0, irq_any}, 8'd0);
    endtask

    task automatic t_route();
        tx_count = CW'(DEPTH - 1); cyc(); cyc();
        chk("R9 tx to irq", {6'b0, irq[1], dma_tx_fill}, 8'b10);
        sel_we = 1; sel_wdata = 2'b01; cyc(); drop_strobes(); cyc();
        chk("R9 tx to dma", {6'b0, irq[1], dma_tx_fill}, 8'b01);
        rx_count = 1; sel_we = 1; sel_wdata = 2'b11; cyc(); drop_strobes(); cyc();
        chk("R9 rx to dma", {6'b0, irq[4], dma_rx_drain}, 8'b01);
        chk("R10 any low with dma", {7'b0, irq_any}, 8'd0);
        sel_we = 1; sel_wdata = 2'b00; cyc(); drop_strobes(); cyc();
        chk("R9 rx back to irq", {6'b0, irq[4], dma_rx_drain}, 8'b10);
        tx_count = CW'(DEPTH); rx_count = 0;
        sel_we = 1; sel_wdata = 2'b11;
        frame_done = 1; eoq_cmd = 1; cyc(); drop_strobes();
        slave_mode = 1; spi_fmt = 1; tx_count = 0; xfer_start_ext = 1;
        rx_count = CW'(DEPTH); rx_frame_in = 1; cyc(); drop_strobes();
        tx_count = CW'(DEPTH); rx_count = 0; cyc(); cyc(); cyc();
        chk("R11 event irqs", {2'b0, irq}, 8'b00101101);
        chk("R11 no dma", {6'b0, dma_tx_fill, dma_rx_drain}, 8'b00);
    endtask

    initial begin
        t_reset();
        t_events();
        t_clear();
        t_fill();
        t_drain();
        t_underflow();
        t_overflow();
        t_irq();
        t_route();
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule